// File: doc/BRIEF.md
# Write-Protected Address Aperture Decoder

This block defines one address window on a system bus and flags every bus address that falls inside it. Two bound registers, each holding the upper 16 bits of a 32-bit address, mark the first and last 64 KB page of the window. Both bounds are inclusive. A small register port lets software read and program the bounds. A separate compare port takes a bus address and returns a hit flag combinationally.

Writes to the bounds are protected by a one-shot arming bit. Software sets the bit and then writes one bound. Accepting that write clears the bit, so every further bound write has to be armed again.

The window switches itself off in two cases: when the high bound is zero, and when the low bound is above the high bound. The second case gives software a safe intermediate state while it moves the window. It first raises the low bound past the high bound, and only then sets the final values.

Top module: `aperture_guard`

## Requirements
- R1: After reset both bounds read 0, the arming bit reads 0 and no address hits.
- R2: The register offsets are 0x0 (low bound), 0x4 (high bound) and 0x8 (arming control, bit 0). A bound sits in bits 31:16 of its word. A read of any other offset returns 0.
- R3: Bits 15:0 of both bound words, and bits 31:1 of the control word, read as 0 whatever value was written to them.
- R4: A write to a bound register while the arming bit is 0 leaves that register unchanged.
- R5: An accepted bound write clears the arming bit at the same clock edge. A second bound write that is not armed again is dropped.
- R6: Writing the control word sets the arming bit to the value of bit 0 of the written data.
- R7: When the window is enabled, an address hits exactly when its bits 31:16 are at least the low bound and at most the high bound.
- R8: When the low bound is greater than the high bound, no address hits.
- R9: When the high bound is 0, no address hits, even when the low bound is also 0.
- R10: The hit flag follows the bus address with no clock delay. A bound change affects the hit flag from the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| bus_addr | input | 32 | Address to classify |
| bus_hit | output | 1 | Address is inside the enabled window |

## Verification
The bench builds the block with its default widths: a 32-bit address, 16-bit bounds and a 4-bit register offset. With these widths every compare edge can be reached directly. This covers a window of a single page, the window that spans the whole address space with a high bound of 0xFFFF, and the page just outside each bound. The bench puts non-zero values in the low address bits and the unused data bits, to show that they play no part in either the hit decision or the stored bounds.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LO,
    SEL_HI,
    SEL_ARM
  } reg_sel_e;

  localparam logic [3:0] OFF_LO  = 4'h0;
  localparam logic [3:0] OFF_HI  = 4'h4;
  localparam logic [3:0] OFF_ARM = 4'h8;

endpackage

// File: rtl/aperture_regs.sv
module aperture_regs
  import aperture_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BOUND_W = 16,
  parameter int REG_AW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic               cfg_wr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic [BOUND_W-1:0] lo_q,
  output logic [BOUND_W-1:0] hi_q,
  output logic               arm_q,
  output logic               bound_wr_ok,
  output logic               bound_wr_drop
);

  localparam int PAD_W = DATA_W - BOUND_W;

  reg_sel_e   sel;
  logic       bound_wr;
  logic [BOUND_W-1:0] wr_field;

  function automatic reg_sel_e decode_off(input logic [REG_AW-1:0] off);
    if (off == REG_AW'(OFF_LO))       return SEL_LO;
    else if (off == REG_AW'(OFF_HI))  return SEL_HI;
    else if (off == REG_AW'(OFF_ARM)) return SEL_ARM;
    else                              return SEL_NONE;
  endfunction

  always_comb begin
    sel           = decode_off(cfg_addr);
    wr_field      = cfg_wdata[DATA_W-1:PAD_W];
    bound_wr      = cfg_wr && ((sel == SEL_LO) || (sel == SEL_HI));
    bound_wr_ok   = bound_wr && arm_q;
    bound_wr_drop = bound_wr && !arm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      arm_q <= 1'b0;
    end else if (bound_wr_ok) begin
      if (sel == SEL_LO) lo_q <= wr_field;
      else               hi_q <= wr_field;
      arm_q <= 1'b0;
    end else if (cfg_wr && (sel == SEL_ARM)) begin
      arm_q <= cfg_wdata[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LO:  cfg_rdata = {lo_q, {PAD_W{1'b0}}};
      SEL_HI:  cfg_rdata = {hi_q, {PAD_W{1'b0}}};
      SEL_ARM: cfg_rdata = {{(DATA_W-1){1'b0}}, arm_q};
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/aperture_match.sv
module aperture_match #(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 16
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BOUND_W-1:0] lo_q,
  input  logic [BOUND_W-1:0] hi_q,
  output logic               win_en,
  output logic               bus_hit
);

  logic [BOUND_W-1:0] page;

  function automatic logic window_live(input logic [BOUND_W-1:0] lo,
                                       input logic [BOUND_W-1:0] hi);
    return (hi != '0) && (lo <= hi);
  endfunction

  function automatic logic page_inside(input logic [BOUND_W-1:0] pg,
                                       input logic [BOUND_W-1:0] lo,
                                       input logic [BOUND_W-1:0] hi);
    return (pg >= lo) && (pg <= hi);
  endfunction

  always_comb begin
    page    = bus_addr[ADDR_W-1 -: BOUND_W];
    win_en  = window_live(lo_q, hi_q);
    bus_hit = win_en && page_inside(page, lo_q, hi_q);
  end

endmodule

// File: rtl/aperture_guard.sv
module aperture_guard #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BOUND_W = 16,
  parameter int REG_AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_hit
);

  logic [BOUND_W-1:0] lo_q;
  logic [BOUND_W-1:0] hi_q;
  logic               arm_q;
  logic               bound_wr_ok;
  logic               bound_wr_drop;
  logic               win_en;

  aperture_regs #(
    .DATA_W (DATA_W),
    .BOUND_W(BOUND_W),
    .REG_AW (REG_AW)
  ) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_addr     (cfg_addr),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .lo_q         (lo_q),
    .hi_q         (hi_q),
    .arm_q        (arm_q),
    .bound_wr_ok  (bound_wr_ok),
    .bound_wr_drop(bound_wr_drop)
  );

  aperture_match #(
    .ADDR_W (ADDR_W),
    .BOUND_W(BOUND_W)
  ) match_i (
    .bus_addr(bus_addr),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .win_en  (win_en),
    .bus_hit (bus_hit)
  );

endmodule

// File: rtl/aperture_guard_chk.sv
module aperture_guard_chk
  import aperture_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BOUND_W = 16,
  parameter int REG_AW  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [REG_AW-1:0]  cfg_addr,
  input logic               cfg_wr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic               bus_hit,
  input logic [BOUND_W-1:0] lo_q,
  input logic [BOUND_W-1:0] hi_q,
  input logic               arm_q,
  input logic               bound_wr_ok,
  input logic               bound_wr_drop
);

  localparam int PAD_W = DATA_W - BOUND_W;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lo_q == '0) && (hi_q == '0) && !arm_q);

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != REG_AW'(OFF_ARM)) |-> (cfg_rdata[PAD_W-1:0] == '0));

  assert_ctrl_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == REG_AW'(OFF_ARM)) |-> (cfg_rdata[DATA_W-1:1] == '0));

  assert_drop_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bound_wr_drop |=> $stable(lo_q) && $stable(hi_q));

  assert_accept_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bound_wr_ok |=> !arm_q);

  assert_arm_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_addr == REG_AW'(OFF_ARM))) |=> (arm_q == $past(cfg_wdata[0])));

  assert_hit_ordered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> (lo_q <= hi_q));

  assert_hit_hi_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> (hi_q != '0));

endmodule

bind aperture_guard aperture_guard_chk #(
  .DATA_W (DATA_W),
  .BOUND_W(BOUND_W),
  .REG_AW (REG_AW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_addr     (cfg_addr),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .bus_hit      (bus_hit),
  .lo_q         (lo_q),
  .hi_q         (hi_q),
  .arm_q        (arm_q),
  .bound_wr_ok  (bound_wr_ok),
  .bound_wr_drop(bound_wr_drop)
);

// File: tb/aperture_guard_tb_top.sv
`timescale 1ns/1ps
module aperture_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] bus_addr = '0;
  logic        bus_hit;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  aperture_guard dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_addr (cfg_addr),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .bus_addr (bus_addr),
    .bus_hit  (bus_hit)
  );

  // {low bound, high bound, page of bus address, expected hit}
  localparam int NV = 10;
  localparam logic [48:0] VEC [NV] = '{
    {16'h0010, 16'h0020, 16'h0010, 1'b1},  // R7 lower edge
    {16'h0010, 16'h0020, 16'h0020, 1'b1},  // R7 upper edge
    {16'h0010, 16'h0020, 16'h000F, 1'b0},  // R7 below
    {16'h0010, 16'h0020, 16'h0021, 1'b0},  // R7 above
    {16'h0010, 16'h0020, 16'h0015, 1'b1},  // R7 middle
    {16'h0030, 16'h0020, 16'h0025, 1'b0},  // R8 inverted
    {16'h0000, 16'h0000, 16'h0000, 1'b0},  // R9 high zero
    {16'h0000, 16'hFFFF, 16'hFFFF, 1'b1},  // R7 full span
    {16'h0042, 16'h0042, 16'h0042, 1'b1},  // R7 single page
    {16'h0042, 16'h0042, 16'h0043, 1'b0}   // R7 single page miss
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #0.5;
    d = cfg_rdata;
  endtask

  task automatic set_window(input logic [15:0] lo, input logic [15:0] hi);
    wr(4'h8, 32'h1);
    wr(4'h0, {lo, 16'h0});
    wr(4'h8, 32'h1);
    wr(4'h4, {hi, 16'h0});
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, r); check("R1 low bound", r, 32'h0);
    rd(4'h4, r); check("R1 high bound", r, 32'h0);
    rd(4'h8, r); check("R1 arm", r, 32'h0);
    bus_addr = 32'h0000_1234; #0.5;
    check("R1 no hit", {31'h0, bus_hit}, 32'h0);

    // R4 write refused while disarmed
    wr(4'h0, 32'h0055_0000);
    rd(4'h0, r); check("R4 low unchanged", r, 32'h0);

    // R6 arm set then cleared by software
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, r); check("R6 arm set", r, 32'h1);
    check("R3 control pad", r & 32'hFFFF_FFFE, 32'h0);
    wr(4'h8, 32'h0);
    rd(4'h8, r); check("R6 arm cleared", r, 32'h0);

    // R5 one-shot arming
    wr(4'h8, 32'h1);
    wr(4'h0, 32'h0012_ABCD);
    rd(4'h8, r); check("R5 arm auto clear", r, 32'h0);
    rd(4'h0, r); check("R3 low pad dropped", r, 32'h0012_0000);
    wr(4'h4, 32'h0034_0000);
    rd(4'h4, r); check("R5 second write dropped", r, 32'h0);

    // R2 undefined offset
    rd(4'hC, r); check("R2 undefined offset", r, 32'h0);

    // vector table: R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      set_window(VEC[i][48:33], VEC[i][32:17]);
      bus_addr = {VEC[i][16:1], 16'hBEEF};
      #0.5;
      check($sformatf("R7/R8/R9 vector %0d", i), {31'h0, bus_hit}, {31'h0, VEC[i][0]});
    end

    // R10 combinational hit and timing of a bound change
    set_window(16'h0100, 16'h0200);
    bus_addr = 32'h0300_0000; #0.5;
    check("R10 comb miss", {31'h0, bus_hit}, 32'h0);
    bus_addr = 32'h0150_0000; #0.5;
    check("R10 comb hit", {31'h0, bus_hit}, 32'h1);
    wr(4'h8, 32'h1);
    @(negedge clk);
    cfg_addr = 4'h4; cfg_wdata = 32'h0120_0000; cfg_wr = 1'b1;
    #0.5;
    check("R10 before edge", {31'h0, bus_hit}, 32'h1);
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R10 after edge", {31'h0, bus_hit}, 32'h0);
    rd(4'h4, r); check("R2 high field position", r, 32'h0120_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule